// File: doc/BRIEF.md
# Qualified Edge-Counting Capture Timer

This block is one timer channel that counts transitions on an external capture pin. The raw pin first passes through a two-flop synchronizer. A glitch qualifier then accepts a new level only after it has held for a minimum number of clocks, two by default. An edge selector passes qualified rising edges, qualified falling edges, or both, as configured.

Each selected edge decrements a 24-bit down-counter. The counter is built from an 8-bit extension word that sits above a 16-bit load word. When the counter reaches a programmed match value it stops, sets a sticky status flag and, if the mask allows, drives the interrupt output. Software sees the number of edges counted since arming as a read-only register. That value is the snapshot of the load value taken at arming minus the live counter.

Software drives the block through a simple register port that uses one address for both writes and reads. It configures the load, match, polarity and mask, then arms the channel. After a match it clears the flag and arms the channel again.

Top module: `edge_count_timer`

Register map (16-bit data, 4-bit address): 0 control (bit0 arm/run, bits2:1 polarity, bit3 interrupt mask), 1 load low word, 2 load extension, 3 match low word, 4 match extension, 5 counter low word, 6 counter extension, 7 status (bit0 match flag), 8 edges-counted low word, 9 edges-counted upper bits. Read data is registered and appears one clock after the address is presented.

## Requirements
- R1: The pin passes through a two-flop synchronizer, and a level that lasts fewer than two clocks after the synchronizer produces no count in any polarity mode.
- R2: A new pin level held for two clocks or longer is qualified and produces exactly one edge of that direction.
- R3: With control bits2:1 = 00, only qualified low-to-high edges decrement the counter.
- R4: With control bits2:1 = 01, only qualified high-to-low edges decrement the counter.
- R5: With control bits2:1 = 10 or 11, every qualified rising edge and every qualified falling edge decrements the counter once.
- R6: Writing control with bit0 = 1 loads the counter with {address 2, address 1}, sets the run bit (control read bit0) and clears the edges-counted value (addresses 8/9).
- R7: Each counted edge lowers the counter (addresses 5/6) by one, and the edges-counted register reads as the armed load value minus the counter.
- R8: When the counter reaches {address 4, address 3}, counting stops, control read bit0 returns 0, and further edges leave the counter unchanged until the channel is armed again.
- R9: A match sets status bit0 (address 7). Writing 1 to that bit clears it, and writing 0 leaves it set.
- R10: irq_o equals status bit0 AND control bit3, delayed by one registered stage.
- R11: After reset all registers read zero, the channel is idle and irq_o is low.
- R12: A pin toggling every two clocks (one quarter of the clock rate) is counted without loss in both-edges mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data, one clock after the address |
| cap_pin | input | 1 | Raw asynchronous capture input |
| irq_o | output | 1 | Match interrupt, masked |

## Verification
The main function is driven with pulse trains that vary the polarity mode, the high time and the low time. Long pulses show that the count depends on the selected polarity. Two-clock pulses sit exactly on the qualification boundary and run at the maximum rate. Single-clock pulses and single-clock dips inside a long high separate a qualifier that filters from one that passes everything. Directed runs cover the arming load, stopping at the match, the write-one-to-clear behaviour and interrupt masking.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    POL_RISE  = 2'b00,
    POL_FALL  = 2'b01,
    POL_BOTH  = 2'b10,
    POL_BOTHX = 2'b11
  } pol_e;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_LDLO   = 4'd1;
  localparam logic [3:0] A_LDHI   = 4'd2;
  localparam logic [3:0] A_MTLO   = 4'd3;
  localparam logic [3:0] A_MTHI   = 4'd4;
  localparam logic [3:0] A_CNTLO  = 4'd5;
  localparam logic [3:0] A_CNTHI  = 4'd6;
  localparam logic [3:0] A_STAT   = 4'd7;
  localparam logic [3:0] A_EDGLO  = 4'd8;
  localparam logic [3:0] A_EDGHI  = 4'd9;
endpackage

// File: rtl/ect_sync.sv
module ect_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ect_qual.sv
module ect_qual
  import ect_pkg::*;
#(
  parameter int QUAL_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_i,
  input  logic [1:0] pol_i,
  output logic       evt_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic          lvl_q;
  logic [QW-1:0] hold_q;
  logic          rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      hold_q <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (s_i != lvl_q) begin
        if (hold_q == QW'(QUAL_CYC - 1)) begin
          lvl_q  <= s_i;
          hold_q <= '0;
          rise_q <= s_i;
          fall_q <= ~s_i;
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end else begin
        hold_q <= '0;
      end
    end
  end

  always_comb begin
    case (pol_e'(pol_i))
      POL_RISE: evt_o = rise_q;
      POL_FALL: evt_o = fall_q;
      default:  evt_o = rise_q | fall_q;
    endcase
  end

  // R2: a qualified edge is one direction only
  assert_one_dir_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_q, fall_q}));
  // R1: the qualified level never moves without an accompanying edge pulse
  assert_no_glitch_R1: assert property (@(posedge clk) disable iff (rst)
    !(rise_q || fall_q) |-> $stable(lvl_q));
  // R3: a rising pulse leaves the qualified level high
  assert_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> lvl_q);
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] base_o,
  output logic             run_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, base_q;
  logic             run_q, hit_q;
  logic [CNT_W-1:0] dec;

  assign dec = cnt_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      base_q <= '0;
      run_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      if (arm_i) begin
        cnt_q  <= load_i;
        base_q <= load_i;
        run_q  <= 1'b1;
      end else if (stop_i) begin
        run_q <= 1'b0;
      end else if (run_q && evt_i) begin
        cnt_q <= dec;
        if (dec == match_i) begin
          run_q <= 1'b0;
          hit_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign base_o = base_q;
  assign run_o  = run_q;
  assign hit_o  = hit_q;

  // R8: an idle counter holds its value
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !arm_i) |=> $stable(cnt_q));
  // R7: a running counter moves down by at most one per clock
  assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !arm_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R8: a match leaves the channel stopped
  assert_stop_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> !run_q);
endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer
  import ect_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int LOAD_W      = 16,
  parameter int QUAL_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        cap_pin,
  output logic        irq_o
);
  localparam int CNT_W = PRE_W + LOAD_W;

  logic [1:0]        pol_q;
  logic              mask_q;
  logic [LOAD_W-1:0] ld_lo_q, mt_lo_q;
  logic [PRE_W-1:0]  ld_hi_q, mt_hi_q;
  logic              flag_q;

  logic              s_pin, evt;
  logic              arm, stop, run, hit;
  logic [CNT_W-1:0]  cnt, base, edges;

  assign arm  = reg_we && reg_addr == A_CTRL && reg_wdata[0];
  assign stop = reg_we && reg_addr == A_CTRL && !reg_wdata[0];

  ect_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(cap_pin), .q_o(s_pin)
  );

  ect_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst(rst), .s_i(s_pin), .pol_i(pol_q), .evt_o(evt)
  );

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .arm_i(arm), .stop_i(stop),
    .load_i({ld_hi_q, ld_lo_q}), .match_i({mt_hi_q, mt_lo_q}),
    .evt_i(evt), .cnt_o(cnt), .base_o(base), .run_o(run), .hit_o(hit)
  );

  assign edges = base - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= 2'b00;
      mask_q  <= 1'b0;
      ld_lo_q <= '0;
      ld_hi_q <= '0;
      mt_lo_q <= '0;
      mt_hi_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          pol_q  <= reg_wdata[2:1];
          mask_q <= reg_wdata[3];
        end
        A_LDLO: ld_lo_q <= reg_wdata[LOAD_W-1:0];
        A_LDHI: ld_hi_q <= reg_wdata[PRE_W-1:0];
        A_MTLO: mt_lo_q <= reg_wdata[LOAD_W-1:0];
        A_MTHI: mt_hi_q <= reg_wdata[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (hit)
        flag_q <= 1'b1;
      else if (reg_we && reg_addr == A_STAT && reg_wdata[0])
        flag_q <= 1'b0;
      irq_o <= flag_q & mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= 16'({mask_q, pol_q, run});
        A_LDLO:  reg_rdata <= 16'(ld_lo_q);
        A_LDHI:  reg_rdata <= 16'(ld_hi_q);
        A_MTLO:  reg_rdata <= 16'(mt_lo_q);
        A_MTHI:  reg_rdata <= 16'(mt_hi_q);
        A_CNTLO: reg_rdata <= 16'(cnt[LOAD_W-1:0]);
        A_CNTHI: reg_rdata <= 16'(cnt[CNT_W-1:LOAD_W]);
        A_STAT:  reg_rdata <= 16'(flag_q);
        A_EDGLO: reg_rdata <= 16'(edges[LOAD_W-1:0]);
        A_EDGHI: reg_rdata <= 16'(edges[CNT_W-1:LOAD_W]);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R9: a one written to the status bit clears it when no match arrives
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_STAT && reg_wdata[0] && !hit) |=> !flag_q);
  // R9: a match always leaves the flag set
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  // R10: the interrupt never rises with the mask clear
  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(mask_q));
endmodule

// File: tb/edge_count_timer_tb.sv
module edge_count_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        cap_pin = 1'b0;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  edge_count_timer u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_pin(cap_pin), .irq_o(irq_o)
  );

  // polarity, high clocks, low clocks, pulse count, expected edges
  localparam int unsigned TBL [8][5] = '{
    '{0, 4, 4, 5, 5},   // R3 rising, long pulses
    '{1, 4, 4, 5, 5},   // R4 falling, long pulses
    '{2, 4, 4, 5, 10},  // R5 both
    '{3, 2, 2, 6, 12},  // R12 / R5 quarter-rate, both (code 11)
    '{0, 1, 4, 5, 0},   // R1 one-clock highs filtered
    '{2, 1, 1, 8, 0},   // R1 one-clock toggles filtered
    '{0, 2, 3, 3, 3},   // R2 two-clock boundary
    '{0, 3, 1, 4, 1}    // R1 one-clock dips do not re-arm rising
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulses(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cap_pin = 1'b1;
      repeat (h - 1) @(negedge clk);
      @(negedge clk); cap_pin = 1'b0;
      repeat (l - 1) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic setup(input logic [23:0] ld, input logic [23:0] mt);
    wr(4'd1, ld[15:0]);
    wr(4'd2, {8'd0, ld[23:16]});
    wr(4'd3, mt[15:0]);
    wr(4'd4, {8'd0, mt[23:16]});
  endtask

  task automatic finish_sim();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_sim();
    end
  end

  initial begin
    logic [15:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(4'd0, v);  check("R11 ctrl", v, 0);
    rd(4'd1, v);  check("R11 load", v, 0);
    rd(4'd5, v);  check("R11 count", v, 0);
    rd(4'd7, v);  check("R11 status", v, 0);
    check("R11 irq", irq_o, 0);

    // R6 arming loads the counter
    setup(24'h12_3456, 24'h00_0000);
    wr(4'd0, 16'h0001);
    rd(4'd5, v);  check("R6 count lo", v, 16'h3456);
    rd(4'd6, v);  check("R6 count hi", v, 16'h0012);
    rd(4'd0, v);  check("R6 run bit", v[0], 1);
    rd(4'd8, v);  check("R6 edges zero", v, 0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      setup(24'd1000, 24'd0);
      wr(4'd0, 16'(((TBL[k][0] & 3) << 1) | 1));
      pulses(int'(TBL[k][1]), int'(TBL[k][2]), int'(TBL[k][3]));
      rd(4'd8, v);
      check($sformatf("R1-vec%0d edges", k), v, 16'(TBL[k][4]));
      rd(4'd5, v2);
      check($sformatf("R7 vec%0d count", k), v2, 16'(1000 - TBL[k][4]));
    end

    // R8 / R9 / R10 match with mask set
    setup(24'd5, 24'd2);
    wr(4'd0, 16'h0009);
    pulses(4, 4, 3);
    rd(4'd5, v);  check("R8 count at match", v, 2);
    rd(4'd0, v);  check("R8 run cleared", v[0], 0);
    rd(4'd7, v);  check("R9 flag set", v, 1);
    check("R10 irq high", irq_o, 1);
    pulses(4, 4, 2);
    rd(4'd5, v);  check("R8 edges ignored after stop", v, 2);
    wr(4'd7, 16'h0000);
    rd(4'd7, v);  check("R9 write zero keeps flag", v, 1);
    wr(4'd7, 16'h0001);
    rd(4'd7, v);  check("R9 w1c clears", v, 0);
    check("R10 irq low after clear", irq_o, 0);

    // R10 masked
    wr(4'd0, 16'h0001);
    pulses(4, 4, 3);
    rd(4'd7, v);  check("R9 flag again", v, 1);
    check("R10 irq masked", irq_o, 0);
    wr(4'd7, 16'h0001);

    done = 1'b1;
    finish_sim();
  end
endmodule